// File: doc/BRIEF.md
# Program Address Sequencer

This block produces the fetch address for a small 8-bit controller core. It holds a 13-bit program counter (PC) and an 8-entry hardware return stack. Every clock it chooses the next address from one source: hold, step by one, step by two for a taken skip, a literal jump or call, a computed write of the low address byte, a pop for a return, or an interrupt vector. Reset overrides all of these. The decoder supplies one-cycle strobes, and the datapath supplies an 11-bit opcode literal, the 8-bit ALU result and a 5-bit upper-address latch.

The upper PC bits are never written directly. A computed write of the low byte takes all five latch bits as PC<12:8>. A literal jump or call takes only latch bits <4:3> as the page number (PC<12:11>), which selects one of four 2K-word pages. The return stack is a ring. Overflow and underflow are silent, and the pointer simply wraps.

Top module: `prog_addr_seq`

## Requirements
- R1: While reset is low, fetch_addr is 0000h. After reset every stack entry holds 0000h, so a return issued straight after reset goes to 0000h.
- R2: An inc_en strobe on its own makes fetch_addr one greater on the next cycle, and 1FFFh wraps to 0000h.
- R3: A skip_en strobe advances fetch_addr by two, modulo 8K.
- R4: A goto_en strobe loads PC<10:0> from lit_k and PC<12:11> from latch_val<4:3>.
- R5: A call_en strobe loads the PC as a goto does and pushes the address of the call plus one, modulo 8K.
- R6: A pclw_en strobe loads PC<7:0> from alu_res and PC<12:8> from latch_val<4:0>.
- R7: An irq_take strobe pushes the current fetch_addr and loads 0004h.
- R8: A ret_en strobe pops the newest stack entry into the PC.
- R9: A reti_en strobe pops in the same way and raises gie_set combinationally in that same cycle. gie_set is low in every other cycle.
- R10: The stack is an 8-entry ring. A ninth push overwrites the oldest entry without any indication, and a pop past the bottom returns the entry the pointer wraps to.
- R11: When strobes coincide, the order is irq_take, then a return (ret_en or reti_en), then call_en, goto_en, pclw_en, skip_en and inc_en. A cycle with no strobe holds the PC. At most one stack operation happens per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_en | input | 1 | Sequential step |
| skip_en | input | 1 | Taken skip (step by two) |
| goto_en | input | 1 | Literal jump |
| call_en | input | 1 | Literal call with push |
| pclw_en | input | 1 | Low PC byte written by the ALU |
| ret_en | input | 1 | Return (plain or with literal), pops |
| reti_en | input | 1 | Return from interrupt, pops and re-enables |
| irq_take | input | 1 | Accepted interrupt |
| lit_k | input | 11 | Opcode address literal |
| alu_res | input | 8 | ALU result byte |
| latch_val | input | 5 | Upper-address latch |
| fetch_addr | output | 13 | Current fetch address (registered PC) |
| gie_set | output | 1 | Interrupt re-enable strobe |

## Verification
fetch_addr is a register. A strobe driven in one cycle is therefore visible on fetch_addr one clock edge later. The driver pushes each expected address as it applies a strobe, and the monitor compares it 1 ns after the next rising edge. gie_set is combinational, so the driver checks it 1 ns after it drives the strobe, before that cycle's edge. The stack cases chain several strobes and check every intermediate address, so a wrong pointer shows up as a wrong popped value.

// File: rtl/prog_addr_pkg.sv
package prog_addr_pkg;

   // Source chosen for the next program counter value
   typedef enum logic [2:0] {
      SRC_HOLD = 3'd0,
      SRC_INC  = 3'd1,
      SRC_SKIP = 3'd2,
      SRC_PCLW = 3'd3,
      SRC_JUMP = 3'd4,
      SRC_POP  = 3'd5,
      SRC_IRQ  = 3'd6
   } addr_src_e;

   // Strobe bundle from the decoder
   typedef struct packed {
      logic irq;
      logic reti;
      logic ret;
      logic call;
      logic jump;
      logic pclw;
      logic skip;
      logic inc;
   } strobe_t;

endpackage

// File: rtl/ret_stack.sv
module ret_stack #(
   parameter int W     = 13,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_en,
   input  logic [W-1:0] push_data,
   input  logic         pop_en,
   output logic [W-1:0] pop_data
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
   localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);

   logic [W-1:0]     slot_q [DEPTH];
   logic [PTR_W-1:0] sp_q;      // next free slot
   logic [PTR_W-1:0] sp_inc;
   logic [PTR_W-1:0] sp_dec;

   initial begin
      assert (DEPTH >= 2) else $error("ret_stack: DEPTH must be at least 2");
      assert (W >= 1)     else $error("ret_stack: W must be positive");
   end

   // The ring wraps for free when DEPTH is a power of two and needs a compare otherwise
   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2
         assign sp_inc = sp_q + ONE;
         assign sp_dec = sp_q - ONE;
      end else begin : g_mod
         assign sp_inc = (sp_q == LAST) ? '0 : sp_q + ONE;
         assign sp_dec = (sp_q == '0) ? LAST : sp_q - ONE;
      end
   endgenerate

   assign pop_data = slot_q[sp_dec];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= '0;
      end else if (push_en) begin
         sp_q <= sp_inc;
      end else if (pop_en) begin
         sp_q <= sp_dec;
      end
   end

   generate
      for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q[gi] <= '0;
            end else if (push_en && (sp_q == PTR_W'(gi))) begin
               slot_q[gi] <= push_data;
            end
         end
      end
   endgenerate

   // R10
   ptr_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_en |=> sp_q == (($past(sp_q) == LAST) ? '0 : $past(sp_q) + ONE));

   // R10
   pop_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_en && !push_en) |=> sp_q == (($past(sp_q) == '0) ? LAST : $past(sp_q) - ONE));

   // R11
   one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_en && pop_en));

endmodule

// File: rtl/next_addr_sel.sv
module next_addr_sel
   import prog_addr_pkg::*;
#(
   parameter int PC_W    = 13,
   parameter int LIT_W   = 11,
   parameter int DATA_W  = 8,
   parameter int IRQ_VEC = 4
) (
   input  strobe_t                  stb,
   input  logic [PC_W-1:0]          pc_q,
   input  logic [LIT_W-1:0]         lit_k,
   input  logic [DATA_W-1:0]        alu_res,
   input  logic [PC_W-DATA_W-1:0]   latch_val,
   input  logic [PC_W-1:0]          pop_data,
   output addr_src_e                src,
   output logic [PC_W-1:0]          next_pc,
   output logic                     push_en,
   output logic [PC_W-1:0]          push_data,
   output logic                     pop_en,
   output logic                     gie_set
);

   localparam int LATCH_W = PC_W - DATA_W;
   localparam int PAGE_W  = PC_W - LIT_W;
   localparam logic [PC_W-1:0] ONE = PC_W'(1);
   localparam logic [PC_W-1:0] TWO = PC_W'(2);
   localparam logic [PC_W-1:0] VEC = PC_W'(IRQ_VEC);

   logic [PC_W-1:0] pc_plus1;
   logic [PC_W-1:0] pc_plus2;
   logic [PC_W-1:0] jump_addr;
   logic [PC_W-1:0] pclw_addr;

   assign pc_plus1  = pc_q + ONE;
   assign pc_plus2  = pc_q + TWO;
   assign pclw_addr = {latch_val, alu_res};

   // The page number comes from the top PAGE_W latch bits
   generate
      if (PAGE_W > 0) begin : g_paged
         assign jump_addr = {latch_val[LATCH_W-1 -: PAGE_W], lit_k};
      end else begin : g_flat
         assign jump_addr = lit_k[PC_W-1:0];
      end
   endgenerate

   always_comb begin
      if (stb.irq)                 src = SRC_IRQ;
      else if (stb.ret || stb.reti) src = SRC_POP;
      else if (stb.call || stb.jump) src = SRC_JUMP;
      else if (stb.pclw)           src = SRC_PCLW;
      else if (stb.skip)           src = SRC_SKIP;
      else if (stb.inc)            src = SRC_INC;
      else                         src = SRC_HOLD;
   end

   always_comb begin
      push_en   = 1'b0;
      push_data = pc_plus1;
      pop_en    = 1'b0;
      gie_set   = 1'b0;
      unique case (src)
         SRC_IRQ: begin
            next_pc   = VEC;
            push_en   = 1'b1;
            push_data = pc_q;
         end
         SRC_POP: begin
            next_pc = pop_data;
            pop_en  = 1'b1;
            gie_set = stb.reti;
         end
         SRC_JUMP: begin
            next_pc = jump_addr;
            push_en = stb.call;
         end
         SRC_PCLW: next_pc = pclw_addr;
         SRC_SKIP: next_pc = pc_plus2;
         SRC_INC:  next_pc = pc_plus1;
         default:  next_pc = pc_q;
      endcase
   end

endmodule

// File: rtl/prog_addr_seq.sv
module prog_addr_seq
   import prog_addr_pkg::*;
#(
   parameter int PC_W    = 13,
   parameter int LIT_W   = 11,
   parameter int DATA_W  = 8,
   parameter int DEPTH   = 8,
   parameter int RST_VEC = 0,
   parameter int IRQ_VEC = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    inc_en,
   input  logic                    skip_en,
   input  logic                    goto_en,
   input  logic                    call_en,
   input  logic                    pclw_en,
   input  logic                    ret_en,
   input  logic                    reti_en,
   input  logic                    irq_take,
   input  logic [LIT_W-1:0]        lit_k,
   input  logic [DATA_W-1:0]       alu_res,
   input  logic [PC_W-DATA_W-1:0]  latch_val,
   output logic [PC_W-1:0]         fetch_addr,
   output logic                    gie_set
);

   localparam int LATCH_W = PC_W - DATA_W;
   localparam int PAGE_W  = PC_W - LIT_W;
   localparam logic [PC_W-1:0] RVEC = PC_W'(RST_VEC);
   localparam logic [PC_W-1:0] IVEC = PC_W'(IRQ_VEC);
   localparam logic [PC_W-1:0] ONE  = PC_W'(1);

   initial begin
      assert (PC_W > DATA_W)   else $error("prog_addr_seq: PC_W must exceed DATA_W");
      assert (PC_W >= LIT_W)   else $error("prog_addr_seq: LIT_W wider than PC_W");
      assert (PAGE_W <= LATCH_W) else $error("prog_addr_seq: latch too narrow for page bits");
      assert (DEPTH >= 2)      else $error("prog_addr_seq: stack needs two entries");
      assert (IRQ_VEC < (1 << PC_W)) else $error("prog_addr_seq: IRQ_VEC out of range");
      assert (RST_VEC < (1 << PC_W)) else $error("prog_addr_seq: RST_VEC out of range");
   end

   strobe_t          stb;
   addr_src_e        src;
   logic [PC_W-1:0]  pc_q;
   logic [PC_W-1:0]  next_pc;
   logic             push_en;
   logic [PC_W-1:0]  push_data;
   logic             pop_en;
   logic [PC_W-1:0]  pop_data;

   assign stb = '{irq: irq_take, reti: reti_en, ret: ret_en, call: call_en,
                  jump: goto_en, pclw: pclw_en, skip: skip_en, inc: inc_en};

   next_addr_sel #(
      .PC_W(PC_W), .LIT_W(LIT_W), .DATA_W(DATA_W), .IRQ_VEC(IRQ_VEC)
   ) sel_i (
      .stb(stb), .pc_q(pc_q), .lit_k(lit_k), .alu_res(alu_res),
      .latch_val(latch_val), .pop_data(pop_data), .src(src),
      .next_pc(next_pc), .push_en(push_en), .push_data(push_data),
      .pop_en(pop_en), .gie_set(gie_set)
   );

   ret_stack #(.W(PC_W), .DEPTH(DEPTH)) stack_i (
      .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_data(push_data),
      .pop_en(pop_en), .pop_data(pop_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= RVEC;
      else        pc_q <= next_pc;
   end

   assign fetch_addr = pc_q;

   // R7
   irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |=> fetch_addr == IVEC);

   // R7
   irq_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> (push_en && push_data == fetch_addr));

   // R9
   gie_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gie_set == (reti_en && !irq_take));

   // R4
   jump_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (goto_en && !irq_take && !ret_en && !reti_en && !call_en) |=>
      fetch_addr == {$past(latch_val[LATCH_W-1 -: PAGE_W]), $past(lit_k)});

   // R2
   seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_en && !skip_en && !pclw_en && !goto_en && !call_en && !ret_en && !reti_en && !irq_take)
      |=> fetch_addr == $past(fetch_addr) + ONE);

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_HOLD) |=> $stable(fetch_addr));

endmodule

// File: tb/prog_addr_seq_tb_top.sv
`timescale 1ns/1ps
module prog_addr_seq_tb_top;

   localparam int S_INC  = 0;
   localparam int S_SKIP = 1;
   localparam int S_GOTO = 2;
   localparam int S_CALL = 3;
   localparam int S_PCLW = 4;
   localparam int S_RET  = 5;
   localparam int S_RETI = 6;
   localparam int S_IRQ  = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  stb = '0;
   logic [10:0] lit_k = '0;
   logic [7:0]  alu_res = '0;
   logic [4:0]  latch_val = '0;
   logic [12:0] fetch_addr;
   logic        gie_set;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [12:0] exp_q[$];
   string       tag_q[$];

   // reference model state
   logic [12:0] m_pc;
   logic [12:0] m_stk [8];
   int          m_sp;

   always #2 clk = ~clk;

   prog_addr_seq dut_i (
      .clk(clk), .rst_n(rst_n),
      .inc_en(stb[S_INC]), .skip_en(stb[S_SKIP]), .goto_en(stb[S_GOTO]),
      .call_en(stb[S_CALL]), .pclw_en(stb[S_PCLW]), .ret_en(stb[S_RET]),
      .reti_en(stb[S_RETI]), .irq_take(stb[S_IRQ]),
      .lit_k(lit_k), .alu_res(alu_res), .latch_val(latch_val),
      .fetch_addr(fetch_addr), .gie_set(gie_set)
   );

   task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: applies one cycle of strobes and queues the address due after the edge
   task automatic apply(input string tag, input logic [7:0] s,
                        input logic [10:0] k, input logic [7:0] a, input logic [4:0] l);
      logic [12:0] nxt;
      logic        g;
      @(negedge clk);
      stb = s; lit_k = k; alu_res = a; latch_val = l;
      g = 1'b0;
      if (s[S_IRQ]) begin
         m_stk[m_sp] = m_pc; m_sp = (m_sp + 1) % 8; nxt = 13'h0004;
      end else if (s[S_RET] || s[S_RETI]) begin
         m_sp = (m_sp + 7) % 8; nxt = m_stk[m_sp]; g = s[S_RETI];
      end else if (s[S_CALL]) begin
         m_stk[m_sp] = m_pc + 13'd1; m_sp = (m_sp + 1) % 8; nxt = {l[4:3], k};
      end else if (s[S_GOTO]) nxt = {l[4:3], k};
      else if (s[S_PCLW])     nxt = {l, a};
      else if (s[S_SKIP])     nxt = m_pc + 13'd2;
      else if (s[S_INC])      nxt = m_pc + 13'd1;
      else                    nxt = m_pc;
      m_pc = nxt;
      exp_q.push_back(nxt);
      tag_q.push_back(tag);
      #1;
      check({tag, " gie_set (R9)"}, {12'd0, gie_set}, {12'd0, g});
   endtask

   // monitor: compares the registered address just after each edge
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         logic [12:0] e;
         string       t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, fetch_addr, e);
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      m_pc = '0;
      m_sp = 0;
      for (int i = 0; i < 8; i++) m_stk[i] = '0;
      repeat (3) @(negedge clk);
      check("R1 address held in reset", fetch_addr, 13'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 address after reset", fetch_addr, 13'h0000);

      apply("R1 R10 pop of cleared stack", 8'(1 << S_RET), '0, '0, '0);
      apply("R2 step", 8'(1 << S_INC), '0, '0, '0);
      apply("R2 step", 8'(1 << S_INC), '0, '0, '0);
      apply("R6 low byte write", 8'(1 << S_PCLW), '0, 8'hFF, 5'h1F);
      apply("R2 wrap to zero", 8'(1 << S_INC), '0, '0, '0);
      apply("R6 low byte write mid page", 8'(1 << S_PCLW), '0, 8'h5A, 5'h0C);
      apply("R4 goto page 1", 8'(1 << S_GOTO), 11'h123, '0, 5'h0A);
      apply("R3 skip", 8'(1 << S_SKIP), '0, '0, '0);
      apply("R5 call page 3", 8'(1 << S_CALL), 11'h7FF, '0, 5'h18);
      apply("R7 interrupt entry", 8'(1 << S_IRQ), '0, '0, '0);
      apply("R9 return from interrupt", 8'(1 << S_RETI), '0, '0, '0);
      apply("R3 skip wraps", 8'(1 << S_SKIP), '0, '0, '0);
      apply("R8 return from call", 8'(1 << S_RET), '0, '0, '0);
      apply("R11 idle holds", 8'h00, 11'h555, 8'hAA, 5'h1F);
      apply("R11 irq beats call and goto",
            8'((1 << S_IRQ) | (1 << S_CALL) | (1 << S_GOTO) | (1 << S_RETI)),
            11'h050, '0, 5'h08);
      apply("R11 return beats call and goto",
            8'((1 << S_RET) | (1 << S_CALL) | (1 << S_GOTO)), 11'h0AA, '0, 5'h00);
      apply("R11 call beats low byte write",
            8'((1 << S_CALL) | (1 << S_PCLW) | (1 << S_INC)), 11'h300, 8'h11, 5'h10);
      apply("R11 low byte write beats skip",
            8'((1 << S_PCLW) | (1 << S_SKIP) | (1 << S_INC)), '0, 8'h42, 5'h03);
      apply("R11 skip beats step", 8'((1 << S_SKIP) | (1 << S_INC)), '0, '0, '0);
      apply("R8 pop after priority call", 8'(1 << S_RET), '0, '0, '0);

      // nine calls overflow the ring, then ten pops walk past the bottom
      for (int i = 0; i < 9; i++)
         apply("R10 nested call", 8'(1 << S_CALL), 11'(i * 16 + 3), '0, 5'(i << 3));
      for (int i = 0; i < 10; i++)
         apply("R10 unwind", 8'(1 << S_RET), '0, '0, '0);

      @(negedge clk);
      stb = '0;
      repeat (3) @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule